// File: doc/BRIEF.md
# Fractional Image Line Resizer

This block resamples a raster stream of 8-bit samples so that each line gets a new pixel count and each frame a new line count. Each axis has its own integer ratio word N. The output size on that axis is the input size times 256/N, so N = 256 passes the geometry through unchanged. Programmed words are clamped to the range 64..1024, which limits the scale to between 4x enlargement and 1/4 reduction.

Samples enter and leave on valid/ready streams that carry frame-start, line-start and line-end flags. The block stores one input line. It then replays that line zero or more times, as the vertical phase decides. During each replay a horizontal phase accumulator walks the stored samples. Each output sample is a linear blend of two neighbouring input samples, weighted by the 8 fractional phase bits.

Back-pressure rules:
- The input side is ready only while a line is being collected. It drops ready once the line-end sample is taken and stays low until every output line drawn from that line has been handed off.
- On the output side, a sample that is offered is held unchanged, with its flags, until it is taken.
- Ratio words are sampled only when a frame-start sample is accepted.

Top module: `rsz_top`

## Requirements
- R1: A ratio word below 64 behaves exactly as 64, and a word above 1024 behaves exactly as 1024, on both axes.
- R2: For an input line of W samples and horizontal ratio Nh, the output line has one sample for each m >= 0 with floor(m*Nh/256) < W. Output sample m is taken at phase position m*Nh, in units of 1/256 input sample.
- R3: Output sample m equals (a*(256-f) + b*f + 128) >> 8. Here i = floor(m*Nh/256), f = (m*Nh) mod 256, a is input sample i and b is input sample i+1.
- R4: When i is the last sample of the line, b is input sample i itself. No sample of another line is ever used.
- R5: Output line j of a frame of H input lines is built from input line floor(j*Nv/256), for every j with floor(j*Nv/256) < H, in increasing j.
- R6: Both ratio words are captured when the frame-start sample is accepted. A change made during a frame has no effect until the next frame start.
- R7: out_sol marks the first sample of every output line and out_eol marks its last. out_sof is set only on the first sample of the first output line of a frame, and always together with out_sol.
- R8: While out_valid is high and out_ready is low, out_valid stays high and out_data, out_sof, out_sol and out_eol hold their values.
- R9: In the cycle after a line-end sample is accepted, in_ready is low.
- R10: After reset, in_ready is high, out_valid is low, and both ratios are 256.
- R11: With both ratio words at 256, every input sample appears unchanged at the output, in order, with the same flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_h_n | input | NW | Horizontal ratio word (output/input = 256/N) |
| cfg_v_n | input | NW | Vertical ratio word |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Block accepts an input sample |
| in_data | input | DW | Input sample |
| in_sof | input | 1 | First sample of a frame (also marks a line start) |
| in_sol | input | 1 | First sample of a line |
| in_eol | input | 1 | Last sample of a line |
| out_valid | output | 1 | Output sample valid |
| out_ready | input | 1 | Downstream accepts the output sample |
| out_data | output | DW | Output sample |
| out_sof | output | 1 | First output sample of a frame |
| out_sol | output | 1 | First output sample of a line |
| out_eol | output | 1 | Last output sample of a line |

## Verification
The bench goes after these corner cases:
- **Right edge under 2x enlargement.** Here the last phase lands halfway past the final sample. A block that read beyond the line would blend in stale data from the previous line.
- **The 1/4 and 4x extremes, and out-of-range words.** A missing or inverted clamp changes the line and sample counts at once.
- **A ratio change in the middle of a frame.** A design that latched ratios continuously would reshape the lines that follow the change.
- **Randomly stalled output.** A design that overwrote its output register during a stall would drop or duplicate samples and break the flag sequence.
- **Vertical skipping and repetition.** Off-by-one phase handling would emit the wrong count of lines or repeat the wrong source line.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
  localparam int NW       = 11;   // width of a ratio word
  localparam int FB       = 8;    // fractional phase bits
  localparam int N_MIN    = 64;
  localparam int N_MAX    = 1024;
  localparam int N_UNITY  = 256;

  typedef enum logic [1:0] {
    ST_FILL   = 2'd0,  // collecting one input line
    ST_DECIDE = 2'd1,  // vertical phase decides emit or skip
    ST_EMIT   = 2'd2   // replaying the stored line
  } rsz_state_e;

  function automatic logic [NW-1:0] clamp_ratio(input logic [NW-1:0] n);
    if (n < NW'(N_MIN))      return NW'(N_MIN);
    else if (n > NW'(N_MAX)) return NW'(N_MAX);
    else                     return n;
  endfunction
endpackage

// File: rtl/rsz_ratio_latch.sv
module rsz_ratio_latch
  import rsz_pkg::*;
#(
  parameter int AXES = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load,
  input  logic [AXES-1:0][NW-1:0]   cfg,
  output logic [AXES-1:0][NW-1:0]   act
);
  logic [NW-1:0] clamped [AXES];

  for (genvar g = 0; g < AXES; g++) begin : g_axis
    assign clamped[g] = clamp_ratio(cfg[g]);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < AXES; k++) begin
      if (rst)       act[k] <= NW'(N_UNITY);
      else if (load) act[k] <= clamped[k];
    end
  end
endmodule

// File: rtl/rsz_line_store.sv
module rsz_line_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/rsz_lerp.sv
module rsz_lerp #(
  parameter int DW = 8,
  parameter int FB = 8
) (
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic [FB-1:0] frac,
  output logic [DW-1:0] y
);
  localparam int SW = DW + FB;  // (2^DW-1)*2^FB + 2^(FB-1) fits in SW bits

  logic [FB:0]   inv;
  logic [SW-1:0] wa, wb, acc;

  always_comb begin
    inv = (FB+1)'(1 << FB) - {1'b0, frac};
    wa  = SW'(a) * SW'(inv);
    wb  = SW'(b) * SW'(frac);
    acc = wa + wb + SW'(1 << (FB-1));
    y   = DW'(acc >> FB);
  end
endmodule

// File: rtl/rsz_top.sv
module rsz_top
  import rsz_pkg::*;
#(
  parameter int DW    = 8,
  parameter int MAX_W = 64,    // longest input line held
  parameter int MAX_H = 1024   // most input lines in a frame
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NW-1:0] cfg_h_n,
  input  logic [NW-1:0] cfg_v_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          in_sof,
  input  logic          in_sol,
  input  logic          in_eol,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data,
  output logic          out_sof,
  output logic          out_sol,
  output logic          out_eol
);
  localparam int AW = $clog2(MAX_W);
  localparam int IW = AW + 2;            // integer part of horizontal phase
  localparam int PW = IW + FB;           // horizontal phase width
  localparam int LW = $clog2(MAX_H) + 1; // line index / vertical integer part
  localparam int VW = LW + FB;           // vertical phase width
  localparam logic [AW:0] WMAX = (AW+1)'(MAX_W);

  rsz_state_e    state;
  logic [AW:0]   wptr;
  logic [AW:0]   width;
  logic [LW-1:0] line_idx;
  logic [VW-1:0] vacc;
  logic [PW-1:0] hpos;
  logic          frame_first;

  logic          accept, fire, last_px;
  logic          wr_en;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] hpos_nxt;
  logic [IW-1:0] idx, idx_b;
  logic [DW-1:0] pix_a, pix_b, blended;
  logic [1:0][NW-1:0] cfg_pair, act_pair;
  logic [NW-1:0] n_h, n_v;

  assign in_ready = (state == ST_FILL);
  assign accept   = in_valid && in_ready;

  // ratio capture at frame start
  assign cfg_pair = {cfg_v_n, cfg_h_n};
  rsz_ratio_latch #(.AXES(2)) u_ratio (
    .clk (clk), .rst (rst), .load (accept && in_sof),
    .cfg (cfg_pair), .act (act_pair)
  );
  assign n_h = act_pair[0];
  assign n_v = act_pair[1];

  // line write side
  always_comb begin
    wr_addr = in_sol ? '0 : wptr[AW-1:0];
    wr_en   = accept && (in_sol || (wptr < WMAX));
  end

  // horizontal phase and neighbour selection
  always_comb begin
    idx      = hpos[PW-1:FB];
    idx_b    = ((idx + IW'(1)) < IW'(width)) ? idx + IW'(1) : idx;
    hpos_nxt = hpos + PW'(n_h);
    last_px  = hpos_nxt[PW-1:FB] >= IW'(width);
    fire     = (state == ST_EMIT) && (!out_valid || out_ready);
  end

  rsz_line_store #(.DW(DW), .DEPTH(MAX_W)) u_store (
    .clk     (clk),
    .we      (wr_en),
    .waddr   (wr_addr),
    .wdata   (in_data),
    .raddr_a (idx[AW-1:0]),
    .raddr_b (idx_b[AW-1:0]),
    .rdata_a (pix_a),
    .rdata_b (pix_b)
  );

  rsz_lerp #(.DW(DW), .FB(FB)) u_lerp (
    .a (pix_a), .b (pix_b), .frac (hpos[FB-1:0]), .y (blended)
  );

  // sequencing
  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_FILL;
      wptr        <= '0;
      width       <= '0;
      line_idx    <= '0;
      vacc        <= '0;
      hpos        <= '0;
      frame_first <= 1'b0;
    end else begin
      unique case (state)
        ST_FILL: if (accept) begin
          if (in_sof) begin
            line_idx    <= '0;
            vacc        <= '0;
            frame_first <= 1'b1;
          end
          if (in_sol)             wptr <= (AW+1)'(1);
          else if (wptr < WMAX)   wptr <= wptr + 1'b1;
          if (in_eol) begin
            if (in_sol)           width <= (AW+1)'(1);
            else if (wptr < WMAX) width <= wptr + 1'b1;
            else                  width <= WMAX;
            state <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          if (vacc[VW-1:FB] == line_idx) begin
            hpos  <= '0;
            state <= ST_EMIT;
          end else begin
            line_idx <= line_idx + 1'b1;
            state    <= ST_FILL;
          end
        end
        ST_EMIT: if (fire) begin
          frame_first <= 1'b0;
          hpos        <= hpos_nxt;
          if (last_px) begin
            vacc  <= vacc + VW'(n_v);
            state <= ST_DECIDE;
          end
        end
        default: state <= ST_FILL;
      endcase
    end
  end

  // output register
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sof   <= 1'b0;
      out_sol   <= 1'b0;
      out_eol   <= 1'b0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= blended;
      out_sol   <= (hpos == '0);
      out_sof   <= frame_first && (hpos == '0);
      out_eol   <= last_px;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/rsz_checker.sv
module rsz_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_eol,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_sof,
  input logic          out_sol,
  input logic          out_eol
);
  logic want_sol;

  always_ff @(posedge clk) begin
    if (rst) want_sol <= 1'b1;
    else if (out_valid && out_ready) want_sol <= out_eol;
  end

  p_reset_idle_r10: assert property (@(posedge clk)
    rst |=> (in_ready && !out_valid));

  p_out_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sof) &&
       $stable(out_sol) && $stable(out_eol)));

  p_sof_with_sol_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_sof) |-> out_sol);

  p_line_start_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && want_sol) |-> out_sol);

  p_eol_blocks_input_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_eol) |=> !in_ready);
endmodule

bind rsz_top rsz_checker #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_eol    (in_eol),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sof   (out_sof),
  .out_sol   (out_sol),
  .out_eol   (out_eol)
);

// File: tb/tb_rsz_top.sv
module tb_rsz_top;
  localparam int DW = 8;
  localparam int NW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NW-1:0] cfg_h_n = NW'(256);
  logic [NW-1:0] cfg_v_n = NW'(256);
  logic          in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, out_valid, out_sof, out_sol, out_eol;
  logic          out_ready = 1'b1;
  logic [DW-1:0] out_data;

  rsz_top #(.DW(DW), .MAX_W(64), .MAX_H(1024)) dut (
    .clk(clk), .rst(rst), .cfg_h_n(cfg_h_n), .cfg_v_n(cfg_v_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_sol(in_sol), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_sol(out_sol), .out_eol(out_eol)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_checks = 0, n_fail = 0, cycles = 0;
  bit stall_en = 0;
  logic [7:0] lfsr = 8'h5a;
  logic [10:0] got_q[$], exp_q[$];
  logic [7:0] img [0:15][0:63];
  int lw [0:15];
  int lh = 0;
  bit prev_stall = 0;
  logic [10:0] prev_word = '0;

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      finish_run();
    end
  end

  // downstream acceptance pattern
  always @(posedge clk) begin
    #1;
    if (stall_en) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      out_ready = lfsr[0] | lfsr[2];
    end else out_ready = 1'b1;
  end

  // output monitor, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (prev_stall)  // R8 hold under back-pressure
        check("R8 hold", {out_valid, out_sof, out_sol, out_eol, out_data},
              {1'b1, prev_word});
      if (out_valid && out_ready) got_q.push_back({out_sof, out_sol, out_eol, out_data});
      prev_stall = out_valid && !out_ready;
      prev_word  = {out_sof, out_sol, out_eol, out_data};
    end
  end

  function automatic int clampn(input int n);
    return (n < 64) ? 64 : (n > 1024) ? 1024 : n;
  endfunction

  task automatic make_img(input int h, input int w, input int seed);
    lh = h;
    for (int l = 0; l < h; l++) begin
      lw[l] = w;
      for (int c = 0; c < 64; c++) img[l][c] = 8'((l * 37 + c * 53 + seed * 11 + c * c * 7) & 255);
    end
  endtask

  task automatic build_exp(input int ch, input int cv);
    int nh, nv, j;
    nh = clampn(ch); nv = clampn(cv); j = 0;
    while (((j * nv) >> 8) < lh) begin
      int src, w, m;
      src = (j * nv) >> 8; w = lw[src]; m = 0;
      while (((m * nh) >> 8) < w) begin
        int idx, f, a, b, v;
        idx = (m * nh) >> 8; f = (m * nh) & 255;
        a = img[src][idx];
        b = (idx + 1 < w) ? int'(img[src][idx + 1]) : a;
        v = (a * (256 - f) + b * f + 128) >> 8;
        exp_q.push_back({(j == 0 && m == 0), (m == 0), ((((m + 1) * nh) >> 8) >= w), 8'(v)});
        m++;
      end
      j++;
    end
  endtask

  task automatic send_pix(input logic [7:0] d, input bit sof, input bit sol, input bit eol);
    bit took;
    in_valid = 1'b1; in_data = d; in_sof = sof; in_sol = sol; in_eol = eol;
    took = 0;
    while (!took) begin
      @(negedge clk); took = in_ready;
      @(posedge clk); #1;
    end
    in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    if (eol) begin
      @(negedge clk);
      check("R9 in_ready after eol", in_ready, 1'b0);
      @(posedge clk); #1;
    end
  endtask

  task automatic send_frame(input int chg_line, input int nh2, input int nv2);
    @(posedge clk); #1;
    for (int l = 0; l < lh; l++) begin
      if (l == chg_line) begin cfg_h_n = NW'(nh2); cfg_v_n = NW'(nv2); end
      for (int c = 0; c < lw[l]; c++)
        send_pix(img[l][c], (l == 0 && c == 0), (c == 0), (c == lw[l] - 1));
    end
  endtask

  task automatic drain_cmp(input string tag);
    int t, n;
    t = 0;
    while ((got_q.size() < exp_q.size() || !in_ready) && t < 20000) begin
      @(negedge clk); t++;
    end
    repeat (30) @(negedge clk);
    check({tag, " sample count"}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) check({tag, " sample"}, got_q[i], exp_q[i]);
    got_q.delete(); exp_q.delete();
  endtask

  task automatic run(input int ch, input int cv, input string tag);
    cfg_h_n = NW'(ch); cfg_v_n = NW'(cv);
    build_exp(ch, cv);
    send_frame(-1, 0, 0);
    drain_cmp(tag);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R10 in_ready after reset", in_ready, 1'b1);
    check("R10 out_valid after reset", out_valid, 1'b0);
  endtask

  task automatic t_identity();  // R11 and R7 markers
    make_img(4, 8, 1);
    run(256, 256, "R11 identity/R7 flags");
    make_img(2, 1, 2);
    run(256, 256, "R11 single-sample lines");
  endtask

  task automatic t_upscale();  // R3 blend, R4 right edge, R8 under stalls
    stall_en = 1;
    make_img(3, 8, 3);
    img[0][6] = 8'd0; img[0][7] = 8'd255;
    run(128, 256, "R3 R4 2x horizontal");
    make_img(2, 5, 4);
    run(64, 256, "R4 4x horizontal edge");
    stall_en = 0;
  endtask

  task automatic t_downscale();  // R2 counts
    make_img(2, 20, 5);
    run(384, 256, "R2 2/3 horizontal");
    make_img(2, 17, 6);
    run(1024, 256, "R2 1/4 horizontal");
    make_img(2, 13, 7);
    run(200, 256, "R2 fractional upscale");
  endtask

  task automatic t_vertical();  // R5
    make_img(5, 6, 8);
    run(256, 128, "R5 2x vertical");
    make_img(9, 4, 9);
    run(256, 1024, "R5 1/4 vertical");
    stall_en = 1;
    make_img(7, 10, 10);
    run(300, 170, "R5 mixed axes");
    stall_en = 0;
  endtask

  task automatic t_clamp();  // R1
    make_img(3, 8, 11);
    run(10, 2000, "R1 clamp low/high");
    make_img(5, 9, 12);
    run(1500, 0, "R1 clamp high/low");
  endtask

  task automatic t_latch();  // R6
    make_img(4, 8, 13);
    cfg_h_n = NW'(256); cfg_v_n = NW'(256);
    build_exp(256, 256);
    send_frame(1, 512, 128);
    drain_cmp("R6 mid-frame change ignored");
    build_exp(512, 128);
    send_frame(-1, 0, 0);
    drain_cmp("R6 change applied next frame");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_identity();
    t_upscale();
    t_downscale();
    t_vertical();
    t_clamp();
    t_latch();
    finish_run();
  end
endmodule